// File: doc/BRIEF.md
# UART FIFO Front-End with Receive Trigger and Transfer Requests

This block sits between a host register port and the serial engine of a classic byte-oriented UART. It keeps two 16-byte queues. Bytes the host writes go into the transmit queue, and a serial shifter drains that queue through a valid/ready handshake. Bytes from a deserializer go into the receive queue, and the host drains that queue by reading the data address. A write-only control address sets the receive interrupt threshold, enables two transfer-request outputs for a DMA engine, and can empty the transmit queue with a one-shot command.

The receive interrupt is level-based. It stays high while the receive queue holds at least the number of bytes selected by a 2-bit code, and the mapping from code to threshold is not linear. Emptying the transmit queue affects only bytes that are still queued. A byte the shifter has already accepted is finished normally. Bytes lost to a full queue in either direction set sticky flags. Reading the status address returns these flags and clears them.

Baud generation, framing, line status and modem control live outside this block. The divisor-latch select bit of the line control register comes in as a plain input.

Top module: `uart_fifo_frontend`

## Requirements
- R1: Each queue holds exactly 16 bytes. Sixteen data writes to an idle transmit queue are all accepted, and a seventeenth is dropped. Sixteen deserializer bytes are all stored, and a seventeenth is dropped. Bytes leave each queue in arrival order.
- R2: `rx_irq` is high exactly while the receive count is at or above the threshold. The 2-bit code in control bits [7:6] selects the threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. The interrupt falls as soon as a read brings the count below the threshold.
- R3: After reset the threshold code is 11, so the threshold is 14 bytes.
- R4: A control write (address 2'b01) with bit 2 set empties the transmit queue, and `tx_valid` is low on the next cycle. A byte that was already handed over on `tx_valid && tx_ready` is not recalled. The next byte written afterwards is the next byte presented.
- R5: A write to the data address (2'b00) queues `host_wdata` for transmit. A read of the data address pops the receive head, and the popped byte appears on `host_rdata` one cycle later.
- R6: While `divisor_access` is 1, reads and writes of the data address have no effect on either queue or on `host_rdata`.
- R7: Control bits 5:4 are ignored. Bit 2 acts only on the cycle it is written and does not repeat. The threshold code and the request-enable bit keep their values until the control address is written again.
- R8: Control bit 3 enables the transfer requests. With it set, `tx_req` is high while the transmit queue is not full, and `rx_req` is high while the receive queue is not empty. With it clear, both requests are low.
- R9: A data write to a full transmit queue is dropped and sets a sticky overflow flag. A read of the status address (2'b10) returns this flag in bit 0 and then clears it.
- R10: A deserializer byte that arrives while the receive queue is full is dropped and sets a sticky overrun flag. The status read returns this flag in bit 1 and then clears it.
- R11: A data read from an empty receive queue returns the last byte popped and leaves the queue pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 00 data, 01 control (write), 10 status (read) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after a read |
| divisor_access | input | 1 | Divisor-latch select from the line control register; blocks data-address access |
| tx_valid | output | 1 | Transmit queue has a byte for the shifter |
| tx_ready | input | 1 | Shifter accepts the presented byte |
| tx_data | output | 8 | Head of the transmit queue |
| rx_valid | input | 1 | Deserializer presents a byte this cycle |
| rx_data | input | 8 | Byte from the deserializer |
| rx_irq | output | 1 | Receive threshold reached |
| tx_req | output | 1 | Transmit transfer request |
| rx_req | output | 1 | Receive transfer request |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle, and that the deserializer cannot be stalled: `rx_valid` is a one-cycle push with no back-pressure. The bench drives each host access as a single-cycle strobe on the falling edge with the other strobe low. It raises `rx_valid` for one cycle per byte, and it holds `tx_ready` low during every control write that clears the transmit queue, so a handover and a clear never land on the same edge.

// File: rtl/uff_pkg.sv
package uff_pkg;

    localparam int BYTE_W     = 8;
    localparam int QUEUE_SLOTS = 16;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'b00,
        ADDR_CTRL = 2'b01,
        ADDR_STAT = 2'b10,
        ADDR_NONE = 2'b11
    } host_addr_e;

    typedef struct packed {
        logic [5:0] zero;
        logic       rx_overrun;
        logic       tx_overflow;
    } status_t;

    // Non-linear decode of the 2-bit receive threshold code.
    function automatic int unsigned trig_threshold(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uff_fifo.sv
module uff_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok = push && (count != CNT_W'(DEPTH));
    assign pop_ok  = pop  && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uff_regs.sv
module uff_regs
    import uff_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [1:0]       ctrl_trig,
    input  logic             ctrl_en,
    input  logic             ctrl_clr,
    input  logic             divisor_access,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic             rx_drop,
    input  logic [WIDTH-1:0] rx_head,
    output logic             tx_push,
    output logic             tx_clr,
    output logic             rx_pop,
    output logic [1:0]       trig_code,
    output logic             dma_en,
    output logic             tx_overflow,
    output logic             rx_overrun,
    output logic [WIDTH-1:0] host_rdata
);

    logic             data_wr;
    logic             data_rd;
    logic             ctrl_wr;
    logic             stat_rd;
    logic [WIDTH-1:0] last_rx;
    status_t          status;

    assign data_wr = host_wr && (host_addr == ADDR_DATA) && !divisor_access;
    assign data_rd = host_rd && (host_addr == ADDR_DATA) && !divisor_access;
    assign ctrl_wr = host_wr && (host_addr == ADDR_CTRL);
    assign stat_rd = host_rd && (host_addr == ADDR_STAT);

    assign tx_push = data_wr && !tx_full;
    assign rx_pop  = data_rd && !rx_empty;
    assign tx_clr  = ctrl_wr && ctrl_clr;

    always_comb begin
        status             = '0;
        status.tx_overflow = tx_overflow;
        status.rx_overrun  = rx_overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_code   <= 2'b11;
            dma_en      <= 1'b0;
            tx_overflow <= 1'b0;
            rx_overrun  <= 1'b0;
            last_rx     <= '0;
            host_rdata  <= '0;
        end else begin
            if (ctrl_wr) begin
                trig_code <= ctrl_trig;
                dma_en    <= ctrl_en;
            end
            if (data_wr && tx_full) begin
                tx_overflow <= 1'b1;
            end else if (stat_rd) begin
                tx_overflow <= 1'b0;
            end
            if (rx_drop) begin
                rx_overrun <= 1'b1;
            end else if (stat_rd) begin
                rx_overrun <= 1'b0;
            end
            if (rx_pop) begin
                last_rx    <= rx_head;
                host_rdata <= rx_head;
            end else if (data_rd) begin
                host_rdata <= last_rx;
            end else if (stat_rd) begin
                host_rdata <= WIDTH'(status);
            end
        end
    end

endmodule

// File: rtl/uff_events.sv
module uff_events
    import uff_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_code,
    input  logic             dma_en,
    input  logic             tx_full,
    input  logic             rx_empty,
    output logic             rx_irq,
    output logic             tx_req,
    output logic             rx_req
);

    logic [CNT_W-1:0] threshold;

    assign threshold = CNT_W'(trig_threshold(trig_code));
    assign rx_irq    = (rx_count >= threshold);
    assign tx_req    = dma_en && !tx_full;
    assign rx_req    = dma_en && !rx_empty;

endmodule

// File: rtl/uart_fifo_frontend.sv
module uart_fifo_frontend
    import uff_pkg::*;
#(
    parameter int WIDTH = BYTE_W,
    parameter int DEPTH = QUEUE_SLOTS,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             divisor_access,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [WIDTH-1:0] tx_data,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_data,
    output logic             rx_irq,
    output logic             tx_req,
    output logic             rx_req
);

    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] rx_count;
    logic [WIDTH-1:0] rx_head;
    logic             tx_full;
    logic             rx_full;
    logic             rx_empty;
    logic             tx_push;
    logic             tx_clr;
    logic             rx_pop;
    logic             rx_drop;
    logic [1:0]       trig_code;
    logic             dma_en;
    logic             tx_overflow;
    logic             rx_overrun;

    assign tx_full  = (tx_count == CNT_W'(DEPTH));
    assign tx_valid = (tx_count != '0);
    assign rx_full  = (rx_count == CNT_W'(DEPTH));
    assign rx_empty = (rx_count == '0);
    assign rx_drop  = rx_valid && rx_full;

    uff_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (tx_push),
        .pop   (tx_valid && tx_ready),
        .wdata (host_wdata),
        .head  (tx_data),
        .count (tx_count)
    );

    uff_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .push  (rx_valid),
        .pop   (rx_pop),
        .wdata (rx_data),
        .head  (rx_head),
        .count (rx_count)
    );

    uff_regs #(.WIDTH(WIDTH)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_addr      (host_addr),
        .ctrl_trig      (host_wdata[7:6]),
        .ctrl_en        (host_wdata[3]),
        .ctrl_clr       (host_wdata[2]),
        .divisor_access (divisor_access),
        .tx_full        (tx_full),
        .rx_empty       (rx_empty),
        .rx_drop        (rx_drop),
        .rx_head        (rx_head),
        .tx_push        (tx_push),
        .tx_clr         (tx_clr),
        .rx_pop         (rx_pop),
        .trig_code      (trig_code),
        .dma_en         (dma_en),
        .tx_overflow    (tx_overflow),
        .rx_overrun     (rx_overrun),
        .host_rdata     (host_rdata)
    );

    uff_events #(.CNT_W(CNT_W)) u_events (
        .rx_count  (rx_count),
        .trig_code (trig_code),
        .dma_en    (dma_en),
        .tx_full   (tx_full),
        .rx_empty  (rx_empty),
        .rx_irq    (rx_irq),
        .tx_req    (tx_req),
        .rx_req    (rx_req)
    );

endmodule

// File: rtl/uff_checker.sv
module uff_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_addr,
    input logic             ctrl_clr_bit,
    input logic             divisor_access,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_irq,
    input logic             tx_req,
    input logic             rx_req,
    input logic             dma_en,
    input logic             tx_full,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             tx_overflow,
    input logic             rx_overrun,
    input logic [CNT_W-1:0] tx_count
);

    p_depth_bound_r1: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CNT_W'(DEPTH));

    p_irq_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> !rx_empty);

    p_quiet_after_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rx_irq);

    p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'b01 && ctrl_clr_bit) |=> !tx_valid);

    p_latch_blocks_write_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'b00 && divisor_access && !(tx_valid && tx_ready))
        |=> tx_count == $past(tx_count));

    p_req_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> (!tx_req && !rx_req));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'b00 && !divisor_access && tx_full) |=> tx_overflow);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full) |=> rx_overrun);

    p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 2'b00 && !divisor_access && rx_empty && !rx_valid)
        |=> rx_empty);

endmodule

bind uart_fifo_frontend uff_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_wr        (host_wr),
    .host_rd        (host_rd),
    .host_addr      (host_addr),
    .ctrl_clr_bit   (host_wdata[2]),
    .divisor_access (divisor_access),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .rx_valid       (rx_valid),
    .rx_irq         (rx_irq),
    .tx_req         (tx_req),
    .rx_req         (rx_req),
    .dma_en         (dma_en),
    .tx_full        (tx_full),
    .rx_full        (rx_full),
    .rx_empty       (rx_empty),
    .tx_overflow    (tx_overflow),
    .rx_overrun     (rx_overrun),
    .tx_count       (tx_count)
);

// File: tb/uart_fifo_frontend_tb.sv
module uart_fifo_frontend_tb;

    localparam logic [1:0] A_DATA = 2'b00;
    localparam logic [1:0] A_CTRL = 2'b01;
    localparam logic [1:0] A_STAT = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'b11;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       divisor_access = 1'b0;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_irq;
    logic       tx_req;
    logic       rx_req;

    int n_checks = 0;
    int n_errors = 0;
    int tx_seen  = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #5 clk = ~clk;

    uart_fifo_frontend u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .divisor_access(divisor_access), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_irq(rx_irq), .tx_req(tx_req), .rx_req(rx_req)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Driver side of the scoreboards.
    task automatic send_tx(input logic [7:0] b, input bit accepted);
        host_write(A_DATA, b);
        if (accepted) tx_q.push_back(b);
    endtask

    task automatic feed_rx(input logic [7:0] b, input bit accepted);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        if (accepted) rx_q.push_back(b);
    endtask

    task automatic take_rx(input string tag);
        logic [7:0] exp;
        host_read(A_DATA);
        exp = rx_q.pop_front();
        check_eq(tag, int'(host_rdata), int'(exp));
    endtask

    task automatic drain_tx();
        @(negedge clk);
        tx_ready = 1'b1;
        repeat (20) @(negedge clk);
        tx_ready = 1'b0;
        check_eq("R1 transmit scoreboard drained", tx_q.size(), 0);
    endtask

    task automatic ctrl(input logic [1:0] code, input bit rsvd, input bit en, input bit clr);
        host_write(A_CTRL, {code, {2{rsvd}}, en, clr, 2'b00});
    endtask

    // Monitor: a handover is seen just after the falling edge preceding it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && tx_valid && tx_ready) begin
                tx_seen++;
                if (tx_q.size() == 0) begin
                    check_eq("R5 unexpected transmit byte", int'(tx_data), -1);
                end else begin
                    check_eq("R5 transmit order", int'(tx_data), int'(tx_q.pop_front()));
                end
            end
        end
    endtask_dummy: begin end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check_eq("R8 reset tx_req", int'(tx_req), 0);
        check_eq("R8 reset rx_req", int'(rx_req), 0);
        check_eq("R4 reset tx_valid", int'(tx_valid), 0);
        check_eq("R2 reset rx_irq", int'(rx_irq), 0);
        host_read(A_STAT);
        check_eq("R9 reset status", int'(host_rdata), 0);

        // Reset threshold is 14
        for (int i = 0; i < 13; i++) feed_rx(8'(8'h30 + i), 1'b1);
        check_eq("R3 irq below 14", int'(rx_irq), 0);
        check_eq("R8 rx_req disabled", int'(rx_req), 0);
        feed_rx(8'h3D, 1'b1);
        check_eq("R3 irq at 14", int'(rx_irq), 1);
        take_rx("R5 receive order");
        check_eq("R2 irq falls below threshold", int'(rx_irq), 0);
        while (rx_q.size() > 0) take_rx("R5 receive order");

        // Empty read returns last byte popped
        host_read(A_DATA);
        check_eq("R11 empty read repeats last", int'(host_rdata), 8'h3D);
        feed_rx(8'hC3, 1'b1);
        take_rx("R11 pointers intact after empty read");

        // Each threshold code, reserved bits toggled on odd codes
        for (int c = 0; c < 4; c++) begin
            int thr;
            thr = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            ctrl(2'(c), c[0], 1'b0, 1'b0);
            for (int i = 0; i < thr - 1; i++) feed_rx(8'(c * 16 + i), 1'b1);
            check_eq($sformatf("R2 code %0d below", c), int'(rx_irq), 0);
            feed_rx(8'hF0, 1'b1);
            check_eq($sformatf("R2 code %0d reached", c), int'(rx_irq), 1);
            host_read(A_STAT);
            check_eq($sformatf("R7 code %0d held after other access", c), int'(rx_irq), 1);
            take_rx("R5 receive order");
            check_eq($sformatf("R2 code %0d falls", c), int'(rx_irq), 0);
            while (rx_q.size() > 0) take_rx("R5 receive order");
        end

        // Requests enabled; fill transmit queue to depth
        ctrl(2'b01, 1'b0, 1'b1, 1'b0);
        check_eq("R8 tx_req with room", int'(tx_req), 1);
        check_eq("R8 rx_req empty", int'(rx_req), 0);
        feed_rx(8'h99, 1'b1);
        check_eq("R8 rx_req with data", int'(rx_req), 1);
        take_rx("R5 receive order");
        for (int i = 0; i < 16; i++) send_tx(8'(8'hA0 + i), 1'b1);
        check_eq("R8 tx_req full", int'(tx_req), 0);
        send_tx(8'hEE, 1'b0);
        host_read(A_STAT);
        check_eq("R9 overflow flag", int'(host_rdata), 1);
        host_read(A_STAT);
        check_eq("R9 overflow cleared", int'(host_rdata), 0);
        tx_seen = 0;
        drain_tx();
        check_eq("R1 sixteen transmitted", tx_seen, 16);

        // Clear leaves handed-over byte alone
        send_tx(8'h11, 1'b1);
        send_tx(8'h22, 1'b0);
        send_tx(8'h33, 1'b0);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check_eq("R4 handed byte taken", tx_q.size(), 0);
        ctrl(2'b01, 1'b0, 1'b1, 1'b1);
        check_eq("R4 cleared tx_valid", int'(tx_valid), 0);
        check_eq("R7 enable held across clear", int'(tx_req), 1);
        send_tx(8'h5A, 1'b1);
        @(negedge clk);
        check_eq("R7 clear does not repeat", int'(tx_valid), 1);
        check_eq("R4 next byte after clear", int'(tx_data), 8'h5A);
        drain_tx();

        // Receive overrun
        for (int i = 0; i < 16; i++) feed_rx(8'(8'h60 + i), 1'b1);
        feed_rx(8'hFF, 1'b0);
        host_read(A_STAT);
        check_eq("R10 overrun flag", int'(host_rdata), 2);
        host_read(A_STAT);
        check_eq("R10 overrun cleared", int'(host_rdata), 0);
        for (int i = 0; i < 16; i++) take_rx("R1 sixteen received in order");

        // Divisor-latch select blocks data access
        divisor_access = 1'b1;
        send_tx(8'h77, 1'b0);
        @(negedge clk);
        check_eq("R6 write blocked", int'(tx_valid), 0);
        feed_rx(8'h44, 1'b1);
        host_read(A_DATA);
        check_eq("R6 read blocked", int'(host_rdata), 8'h6F);
        divisor_access = 1'b0;
        take_rx("R6 byte still queued");

        finish_run();
    end

endmodule